// File: doc/BRIEF.md
# Write-Protected Wakeup Countdown Timer

This block is a periodic wakeup timer that counts a slow tick (nominally one pulse per second, presented as a one-cycle enable in the system clock domain). When the programmed number of ticks has elapsed it latches a wakeup flag, raises a level interrupt if that is enabled, and emits a one-cycle wake pulse. The wake pulse lets power-management logic bring the system out of its stop mode. The counter then reloads itself and keeps counting, so the wakeups repeat.

The control and reload registers are guarded against stray writes. Software unlocks them by writing two key bytes in order to a key register. Changing the period needs a handshake. Software first stops the timer. It then waits until a write-permitted status bit reads 1, which happens two ticks after the stop. Only then does it load the new reload value and start the timer again with its interrupt enable.

The register interface is a simple single-cycle write port with a combinational read port. Address 0 is the key register, address 1 is control, address 2 is reload, and address 3 is status. A read of address 0 returns zero.

Top module: `wake_timer`

## Requirements
- R1: The registers unlock only when the low byte 0xCA and then the low byte 0x53 are written to the key register (address 0) in that order. Status bit 2 reads 1 while they are unlocked. After reset they are locked.
- R2: Any other write to the key register locks the registers again. This includes 0x53 without a preceding 0xCA, and any write made while already unlocked. A write of 0xCA always re-arms the sequence. While locked, writes to control and reload are ignored.
- R3: Control (address 1) holds bit 0 = run and bit 1 = interrupt enable, and both reset to 0. A control write is accepted only while the registers are unlocked.
- R4: The 16-bit reload register (address 2) resets to 0xFFFF. A write to it is accepted only when three conditions all hold: the registers are unlocked, run is 0, and the write-permitted bit is 1. Any other reload write is ignored.
- R5: The write-permitted bit (status bit 0) resets to 1. It reads 0 from the cycle after the write that sets run. After run is cleared it reads 1 once the second tick following the clear has been taken.
- R6: With reload value N, the wakeup flag (status bit 1) sets on the (N+1)-th tick after run is set. The counter then reloads, and the next expiry follows after another N+1 ticks.
- R7: Writing status with bit 1 = 0 clears the flag, and writing bit 1 = 1 leaves it unchanged. This clear works even while the registers are locked. If an expiry and a clear fall in the same cycle, the flag stays set.
- R8: The interrupt output is high exactly while the flag is set and the interrupt enable is 1.
- R9: The wake output is a one-cycle pulse in the cycle after each expiry tick, whatever the interrupt enable is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle pulse per timer tick |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register select |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr`, combinational |
| irq | output | 1 | Level interrupt: flag and enable both set |
| wake | output | 1 | One-cycle wake pulse on each expiry |

## Verification
A register write takes effect at the clock edge that samples it. The bench therefore reads back on the following low clock phase. A tick's effects (flag, interrupt, wake pulse) become visible right after the edge that samples the tick, and the wake pulse lasts only that one cycle. The bench samples wake at that point and again one cycle later. The write-permitted bit is checked after each of the two ticks that follow a stop, so both "still 0" and "now 1" are pinned to the exact tick. The expiry sweep counts ticks for each small reload value, checks the flag low after N ticks and high after N+1, and repeats this over a second period.

// File: rtl/wake_timer_pkg.sv
package wake_timer_pkg;

    localparam int ADDR_W = 2;
    localparam logic [7:0] KEY_FIRST  = 8'hCA;
    localparam logic [7:0] KEY_SECOND = 8'h53;

    typedef enum logic [ADDR_W-1:0] {
        REG_KEY    = 2'd0,
        REG_CTRL   = 2'd1,
        REG_RELOAD = 2'd2,
        REG_STATUS = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        GUARD_SHUT,
        GUARD_ARMED,
        GUARD_OPEN
    } guard_e;

    typedef struct packed {
        logic irq_en;
        logic run;
    } ctrl_t;

    typedef struct packed {
        logic open;
        logic flag;
        logic wr_ok;
    } status_t;

    function automatic guard_e guard_next(guard_e cur, logic [7:0] key);
        if (key == KEY_FIRST)
            return GUARD_ARMED;
        else if (key == KEY_SECOND && cur == GUARD_ARMED)
            return GUARD_OPEN;
        else
            return GUARD_SHUT;
    endfunction

endpackage

// File: rtl/wkt_guard.sv
module wkt_guard
    import wake_timer_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       key_wr,
    input  logic [7:0] key,
    output logic       open
);

    guard_e st;

    always_ff @(posedge clk) begin
        if (rst)
            st <= GUARD_SHUT;
        else if (key_wr)
            st <= guard_next(st, key);
    end

    assign open = (st == GUARD_OPEN);

    // R1
    unlock_order_chk: assert property (@(posedge clk) disable iff (rst)
        (open && !$past(open)) |-> $past(key_wr && key == KEY_SECOND));

    // R2
    relock_chk: assert property (@(posedge clk) disable iff (rst)
        (open && key_wr) |=> !open);

endmodule

// File: rtl/wkt_access_sync.sv
module wkt_access_sync #(
    parameter int SYNC_TICKS = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic run_q,
    input  logic run_nxt,
    output logic wr_ok
);

    localparam int CW = $clog2(SYNC_TICKS + 1);

    logic [CW-1:0] seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen  <= '0;
            wr_ok <= 1'b1;
        end else if (run_nxt || run_q) begin
            seen  <= '0;
            wr_ok <= 1'b0;
        end else if (!wr_ok && tick) begin
            if (seen == CW'(SYNC_TICKS - 1)) begin
                seen  <= '0;
                wr_ok <= 1'b1;
            end else begin
                seen <= seen + 1'b1;
            end
        end
    end

    // R5
    wr_ok_low_when_run_chk: assert property (@(posedge clk) disable iff (rst)
        run_q |-> !wr_ok);

    // R5
    wr_ok_rise_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(wr_ok) |-> $past(tick && !run_q));

endmodule

// File: rtl/wkt_countdown.sv
module wkt_countdown #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             run_q,
    input  logic             load,
    input  logic [CNT_W-1:0] reload,
    input  logic             flag_clr,
    output logic             flag,
    output logic             wake
);

    logic [CNT_W-1:0] cnt;
    logic             expire;

    assign expire = run_q && tick && (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            flag <= 1'b0;
            wake <= 1'b0;
        end else begin
            wake <= expire;
            if (load)
                cnt <= reload;
            else if (run_q && tick)
                cnt <= (cnt == '0) ? reload : cnt - 1'b1;
            if (expire)
                flag <= 1'b1;
            else if (flag_clr)
                flag <= 1'b0;
        end
    end

    // R6
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        run_q |-> (cnt <= reload));

    // R6
    flag_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(flag) |-> $past(tick && run_q));

    // R9
    wake_with_flag_chk: assert property (@(posedge clk) disable iff (rst)
        wake |-> flag);

endmodule

// File: rtl/wake_timer.sv
module wake_timer
    import wake_timer_pkg::*;
#(
    parameter int CNT_W      = 16,
    parameter int SYNC_TICKS = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CNT_W-1:0]  wdata,
    output logic [CNT_W-1:0]  rdata,
    output logic              irq,
    output logic              wake
);

    localparam logic [CNT_W-1:0] RELOAD_RST = '1;

    reg_sel_e         sel;
    ctrl_t            ctrl_q;
    logic [CNT_W-1:0] reload_q;
    logic             open, wr_ok, flag;
    logic             key_wr, ctrl_we, reload_we, flag_clr;
    logic             run_nxt, load;
    status_t          stat;

    assign sel       = reg_sel_e'(addr);
    assign key_wr    = wr_en && sel == REG_KEY;
    assign ctrl_we   = wr_en && sel == REG_CTRL && open;
    assign reload_we = wr_en && sel == REG_RELOAD && open && !ctrl_q.run && wr_ok;
    assign flag_clr  = wr_en && sel == REG_STATUS && !wdata[1];
    assign run_nxt   = ctrl_we ? wdata[0] : ctrl_q.run;
    assign load      = run_nxt && !ctrl_q.run;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q   <= '0;
            reload_q <= RELOAD_RST;
        end else begin
            if (ctrl_we)
                ctrl_q <= ctrl_t'(wdata[1:0]);
            if (reload_we)
                reload_q <= wdata;
        end
    end

    wkt_guard u_guard (
        .clk    (clk),
        .rst    (rst),
        .key_wr (key_wr),
        .key    (wdata[7:0]),
        .open   (open)
    );

    wkt_access_sync #(.SYNC_TICKS(SYNC_TICKS)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .run_q   (ctrl_q.run),
        .run_nxt (run_nxt),
        .wr_ok   (wr_ok)
    );

    wkt_countdown #(.CNT_W(CNT_W)) u_count (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .run_q    (ctrl_q.run),
        .load     (load),
        .reload   (reload_q),
        .flag_clr (flag_clr),
        .flag     (flag),
        .wake     (wake)
    );

    assign stat = '{open: open, flag: flag, wr_ok: wr_ok};
    assign irq  = flag && ctrl_q.irq_en;

    always_comb begin
        case (sel)
            REG_CTRL:   rdata = CNT_W'(ctrl_q);
            REG_RELOAD: rdata = reload_q;
            REG_STATUS: rdata = CNT_W'(stat);
            default:    rdata = '0;
        endcase
    end

    // R4
    reload_hold_run_chk: assert property (@(posedge clk) disable iff (rst)
        ctrl_q.run |=> $stable(reload_q));

    // R2
    reload_hold_locked_chk: assert property (@(posedge clk) disable iff (rst)
        !open |=> $stable(reload_q));

    // R3
    ctrl_hold_locked_chk: assert property (@(posedge clk) disable iff (rst)
        !open |=> $stable(ctrl_q));

endmodule

// File: tb/wake_timer_tb_top.sv
module wake_timer_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [15:0] wdata = 16'd0;
    logic [15:0] rdata;
    logic        irq, wake;

    int vectors = 0;
    int fails   = 0;

    always #2 clk = ~clk;

    wake_timer dut_i (
        .clk   (clk),
        .rst   (rst),
        .tick  (tick),
        .wr_en (wr_en),
        .addr  (addr),
        .wdata (wdata),
        .rdata (rdata),
        .irq   (irq),
        .wake  (wake)
    );

    localparam logic [1:0] A_KEY = 2'd0, A_CTRL = 2'd1, A_RLD = 2'd2, A_STAT = 2'd3;

    task automatic check(input string tag, input int act, input int exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output int d);
        addr = a;
        #1;
        d = int'(rdata);
    endtask

    task automatic pulse_tick;
        @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic stat_bit(input int b, output int v);
        int s;
        rd(A_STAT, s);
        v = (s >> b) & 1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        int d, b;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // reset state
        rd(A_CTRL, d);  check("R3 ctrl reset", d, 0);
        rd(A_RLD, d);   check("R4 reload reset", d, 16'hFFFF);
        rd(A_STAT, d);  check("R5/R1 status reset", d, 1);
        check("R8 irq reset", irq, 0);
        check("R9 wake reset", wake, 0);

        // locked writes ignored
        wr(A_CTRL, 16'h3);   rd(A_CTRL, d); check("R2 locked ctrl", d, 0);
        wr(A_RLD, 16'h5);    rd(A_RLD, d);  check("R2 locked reload", d, 16'hFFFF);

        // reversed key order stays locked
        wr(A_KEY, 16'h53); wr(A_KEY, 16'hCA);
        stat_bit(2, b); check("R1 reversed order", b, 0);

        // sweep all first key bytes
        for (int v = 0; v < 256; v++) begin
            wr(A_KEY, 16'(v));
            wr(A_KEY, 16'h53);
            stat_bit(2, b); check("R1 unlock sweep", b, (v == 8'hCA) ? 1 : 0);
            wr(A_KEY, 16'h00);
            stat_bit(2, b); check("R2 relock sweep", b, 0);
        end

        // a write while open relocks, including a second 0x53
        wr(A_KEY, 16'hCA); wr(A_KEY, 16'h53); wr(A_KEY, 16'h53);
        stat_bit(2, b); check("R2 repeat second key", b, 0);

        wr(A_KEY, 16'hCA); wr(A_KEY, 16'h53);

        // expiry sweep over small reload values
        for (int r = 0; r < 6; r++) begin
            wr(A_RLD, 16'(r));
            rd(A_RLD, d); check("R4 reload accepted", d, r);
            wr(A_CTRL, 16'h1);
            stat_bit(0, b); check("R5 wr_ok falls on run", b, 0);
            rd(A_CTRL, d); check("R3 ctrl run", d, 1);
            wr(A_RLD, 16'h9);
            rd(A_RLD, d); check("R4 reload ignored while running", d, r);
            for (int p = 0; p < 2; p++) begin
                for (int k = 0; k < r; k++) begin
                    pulse_tick;
                    stat_bit(1, b); check("R6 flag low before period", b, 0);
                end
                pulse_tick;
                check("R9 wake pulse", wake, 1);
                stat_bit(1, b); check("R6 flag at period end", b, 1);
                check("R8 irq masked", irq, 0);
                @(negedge clk);
                check("R9 wake one cycle", wake, 0);
                wr(A_STAT, 16'h0);
                stat_bit(1, b); check("R7 flag cleared", b, 0);
            end
            wr(A_CTRL, 16'h0);
            stat_bit(0, b); check("R5 wr_ok low after stop", b, 0);
            wr(A_RLD, 16'h9);
            rd(A_RLD, d); check("R4 reload ignored before wr_ok", d, r);
            pulse_tick;
            stat_bit(0, b); check("R5 wr_ok low after one tick", b, 0);
            pulse_tick;
            stat_bit(0, b); check("R5 wr_ok high after two ticks", b, 1);
        end

        // interrupt, set-wins, write-1 no effect
        wr(A_RLD, 16'h0);
        wr(A_CTRL, 16'h3);
        pulse_tick;
        check("R8 irq with enable", irq, 1);
        wr(A_STAT, 16'h2);
        stat_bit(1, b); check("R7 write one keeps flag", b, 1);
        @(negedge clk);
        wr_en = 1'b1; addr = A_STAT; wdata = 16'h0; tick = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; tick = 1'b0;
        stat_bit(1, b); check("R7 expiry beats clear", b, 1);
        wr(A_STAT, 16'h0);
        check("R8 irq drops with flag", irq, 0);
        wr(A_CTRL, 16'h1);
        pulse_tick;
        check("R9 wake without irq enable", wake, 1);
        check("R8 irq off with flag set", irq, 0);
        wr(A_STAT, 16'h0);

        // relock; ctrl frozen, flag clear still allowed
        wr(A_KEY, 16'h11);
        stat_bit(2, b); check("R2 relock by other key", b, 0);
        wr(A_CTRL, 16'h0);
        rd(A_CTRL, d); check("R2 locked ctrl unchanged", d, 1);
        pulse_tick;
        stat_bit(1, b); check("R6 still running when locked", b, 1);
        wr(A_STAT, 16'h0);
        stat_bit(1, b); check("R7 clear while locked", b, 0);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule